// File: doc/BRIEF.md
# Byte-Serial Transfer Data-Phase DMA Engine

This block carries out the data phase of a transfer one byte per beat. It moves data between a local byte buffer and host memory. When an idle engine sees a start strobe, it captures three inputs: the transfer size decoded earlier, a host base address, and a direction flag. With the direction flag high, buffer bytes are copied out to memory. With it low, memory bytes are copied into the buffer. Byte i always uses buffer index i and host address base + i. Address translation happens outside this block.

The memory side is a valid/ready request port. While the engine is busy, `mem_req_valid` stays high, and the address, write flag and write data stay fixed until the cycle in which `mem_req_ready` is high. That cycle is the acknowledge for the byte. For a read, the memory must present `mem_rdata` in the same cycle in which it raises ready. Memory applies back-pressure by holding ready low, and no limit is placed on how long it may do so. The buffer port reads combinationally (`buf_rdata` follows `buf_addr`) and writes on `buf_we`.

When the transfer finishes, the engine loads completion codes into its status, interrupt and sequence outputs, sets a sticky done flag and raises the interrupt line. The codes are the same for both directions.

Top module: `sbx_dma_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `dma_done` and `mem_req_valid` are 0, and `stat_o`, `intr_o` and `seq_o` are 0x00.
- R2: A start accepted while idle latches `xfer_len`, `dma_base` and `to_mem`. If the length is nonzero, `busy` and `mem_req_valid` are high from the next cycle. Byte i is requested at address `dma_base + i`. The address holds until ready, then advances by one.
- R3: With `to_mem`=1, every request has `mem_req_write`=1 and `mem_req_wdata` equal to the buffer byte at index i, and `buf_addr`=i.
- R4: With `to_mem`=0, every request has `mem_req_write`=0. In the acknowledge cycle, `buf_we`=1, `buf_addr`=i and `buf_wdata`=`mem_rdata`. `buf_we` is 0 at every other time.
- R5: On the clock edge that acknowledges the last byte, `busy` drops. At the same edge `stat_o` becomes 0x93 (bit7 interrupt, bit4 terminal count, bits 2:0 = 3, status phase), `intr_o` becomes 0x10 (bit4 bus service), `seq_o` becomes 0x00, and `dma_done` and `irq` become 1. This happens in both directions.
- R6: A start with `xfer_len`=0 issues no memory request and never raises `busy`. It applies the R5 completion updates at the same edge that accepts the start.
- R7: A start strobe that arrives while `busy` is high is ignored. The length, base address and direction of the running transfer do not change.
- R8: `irq_ack` clears `irq` at the next edge unless a completion happens at that edge, in which case completion wins. `dma_done` stays set until the next accepted start clears it.
- R9: `mem_req_valid` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; acted on only when idle |
| xfer_len | input | LEN_W | Number of bytes to move |
| to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| dma_base | input | AW | Host address of byte 0 |
| irq_ack | input | 1 | Clears the interrupt line |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request (byte acknowledge) |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with ready |
| buf_addr | output | LEN_W | Buffer index of the current byte |
| buf_rdata | input | 8 | Buffer byte at `buf_addr` |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Interrupt line |
| dma_done | output | 1 | Sticky completion flag |
| stat_o | output | 8 | Status code |
| intr_o | output | 8 | Interrupt cause code |
| seq_o | output | 8 | Sequence step |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a stalled transfer while memory is holding ready low. That strobe must leave the latched base, length and direction untouched. The bench reaches this case by throttling ready on a fixed pattern and pulsing start again, with a different base and length, two cycles into a running transfer. The cycle-level reference model then shows whether any later address deviates. A zero-length start and an interrupt acknowledge issued after completion are also covered. In those cases the outputs that would move show no change other than the expected one.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam logic [7:0] STAT_DONE = 8'h93;
  localparam logic [7:0] INTR_DONE = 8'h10;
  localparam logic [7:0] SEQ_DONE  = 8'h00;
  typedef enum logic {S_IDLE, S_RUN} run_e;
endpackage

// File: rtl/sbx_ctrl.sv
module sbx_ctrl
  import sbx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic [AW-1:0]    base_in,
  input  logic             dir_in,
  input  logic             beat_ok,
  input  logic             last,
  output logic             busy,
  output logic             accept,
  output logic             load,
  output logic             finish,
  output logic [LEN_W-1:0] len_q,
  output logic [AW-1:0]    base_q,
  output logic             dir_q
);
  run_e state;
  logic zero_len;

  assign zero_len = (len_in == '0);
  assign accept   = start && (state == S_IDLE);
  assign load     = accept && !zero_len;
  assign finish   = (accept && zero_len) || ((state == S_RUN) && beat_ok && last);
  assign busy     = (state == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      len_q  <= '0;
      base_q <= '0;
      dir_q  <= 1'b0;
    end else if (load) begin
      state  <= S_RUN;
      len_q  <= len_in;
      base_q <= base_in;
      dir_q  <= dir_in;
    end else if (finish) begin
      state  <= S_IDLE;
    end
  end
endmodule

// File: rtl/sbx_index_ctr.sv
module sbx_index_ctr #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] len_q,
  input  logic [AW-1:0]    base_q,
  output logic [LEN_W-1:0] idx,
  output logic [AW-1:0]    addr,
  output logic             last
);
  localparam int PAD = AW - LEN_W;

  assign addr = base_q + {{PAD{1'b0}}, idx};
  assign last = (idx == (len_q - LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= idx + LEN_W'(1);
  end
endmodule

// File: rtl/sbx_status.sv
module sbx_status
  import sbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       finish,
  input  logic       irq_ack,
  output logic       irq,
  output logic       done,
  output logic [7:0] stat,
  output logic [7:0] intr,
  output logic [7:0] seq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      done <= 1'b0;
      stat <= 8'h00;
      intr <= 8'h00;
      seq  <= 8'h00;
    end else begin
      if (finish) begin
        irq  <= 1'b1;
        done <= 1'b1;
        stat <= STAT_DONE;
        intr <= INTR_DONE;
        seq  <= SEQ_DONE;
      end else begin
        if (irq_ack) irq  <= 1'b0;
        if (accept)  done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbx_dma_engine.sv
module sbx_dma_engine #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             to_mem,
  input  logic [AW-1:0]    dma_base,
  input  logic             irq_ack,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [7:0]       mem_req_wdata,
  input  logic [7:0]       mem_rdata,
  output logic [LEN_W-1:0] buf_addr,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  output logic             busy,
  output logic             irq,
  output logic             dma_done,
  output logic [7:0]       stat_o,
  output logic [7:0]       intr_o,
  output logic [7:0]       seq_o
);
  logic             accept, load, finish, last, beat_ok, dir_q;
  logic [LEN_W-1:0] len_q, idx;
  logic [AW-1:0]    base_q;

  assign beat_ok = busy && mem_req_ready;

  sbx_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(xfer_len),
    .base_in(dma_base), .dir_in(to_mem), .beat_ok(beat_ok), .last(last),
    .busy(busy), .accept(accept), .load(load), .finish(finish),
    .len_q(len_q), .base_q(base_q), .dir_q(dir_q)
  );

  sbx_index_ctr #(.AW(AW), .LEN_W(LEN_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(beat_ok),
    .len_q(len_q), .base_q(base_q), .idx(idx), .addr(mem_req_addr), .last(last)
  );

  sbx_status u_stat (
    .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish),
    .irq_ack(irq_ack), .irq(irq), .done(dma_done),
    .stat(stat_o), .intr(intr_o), .seq(seq_o)
  );

  assign mem_req_valid = busy;
  assign mem_req_write = dir_q;
  assign mem_req_wdata = buf_rdata;
  assign buf_addr      = idx;
  assign buf_we        = beat_ok && !dir_q;
  assign buf_wdata     = mem_rdata;
endmodule

// File: rtl/sbx_dma_checks.sv
module sbx_dma_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          irq,
  input logic          dma_done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic          buf_we,
  input logic [7:0]    stat_o,
  input logic [7:0]    intr_o,
  input logic [7:0]    seq_o
);
  a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid || (mem_req_addr == $past(mem_req_addr) + AW'(1)));

  a_r5_done_codes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat_o == 8'h93) && (intr_o == 8'h10) && (seq_o == 8'h00) && dma_done);

  a_r4_buf_we_read: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> mem_req_valid && mem_req_ready && !mem_req_write);

  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind sbx_dma_engine sbx_dma_checks #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .irq(irq),
  .dma_done(dma_done), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .buf_we(buf_we),
  .stat_o(stat_o), .intr_o(intr_o), .seq_o(seq_o)
);

// File: tb/sim_sbx_dma_engine.sv
module sim_sbx_dma_engine;
  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 0, rst_n = 0, start = 0, to_mem = 0, irq_ack = 0, rdy = 0;
  logic [LW-1:0] xfer_len = '0;
  logic [AW-1:0] dma_base = '0;
  logic mem_req_valid, mem_req_write, buf_we, busy, irq, dma_done;
  logic [AW-1:0] mem_req_addr;
  logic [7:0] mem_req_wdata, mem_rdata, buf_rdata, buf_wdata, stat_o, intr_o, seq_o;
  logic [LW-1:0] buf_addr;

  logic [7:0] mem [256];
  logic [7:0] bufm [256];
  int vectors = 0, errors = 0, cyc = 0, rmode = 0;
  bit finished = 0;

  int m_busy, m_idx, m_len, m_base, m_dir, m_irq, m_done, m_stat, m_intr, m_seq;

  always #5 clk = ~clk;

  sbx_dma_engine #(.AW(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len), .to_mem(to_mem),
    .dma_base(dma_base), .irq_ack(irq_ack), .mem_req_valid(mem_req_valid),
    .mem_req_ready(rdy), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata), .buf_addr(buf_addr),
    .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata), .busy(busy),
    .irq(irq), .dma_done(dma_done), .stat_o(stat_o), .intr_o(intr_o), .seq_o(seq_o)
  );

  assign mem_rdata = mem[mem_req_addr[7:0]];
  assign buf_rdata = bufm[buf_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req_valid && rdy && mem_req_write) mem[mem_req_addr[7:0]] <= mem_req_wdata;
    if (buf_we) bufm[buf_addr[7:0]] <= buf_wdata;
  end

  always @(posedge clk) begin
    cyc++;
    #1 rdy = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // reference model
  always @(posedge clk) begin
    bit fin;
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_len = 0; m_base = 0; m_dir = 0;
      m_irq = 0; m_done = 0; m_stat = 0; m_intr = 0; m_seq = 0;
    end else begin
      fin = 0;
      if (m_busy != 0) begin
        if (rdy) begin
          if (m_idx == m_len - 1) begin m_busy = 0; fin = 1; end
          else m_idx++;
        end
      end else if (start) begin
        m_done = 0;
        if (xfer_len == 0) fin = 1;
        else begin
          m_busy = 1; m_idx = 0; m_len = int'(xfer_len);
          m_base = int'(dma_base); m_dir = int'(to_mem);
        end
      end
      if (fin) begin
        m_irq = 1; m_done = 1; m_stat = 'h93; m_intr = 'h10; m_seq = 0;
      end else if (irq_ack) m_irq = 0;
    end
  end

  task automatic cmp(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("R2 busy", busy, m_busy);
      cmp("R8 irq", irq, m_irq);
      cmp("R5 dma_done", dma_done, m_done);
      cmp("R5 stat_o", stat_o, m_stat);
      cmp("R5 intr_o", intr_o, m_intr);
      cmp("R5 seq_o", seq_o, m_seq);
      cmp("R9 mem_req_valid", mem_req_valid, m_busy);
      if (m_busy != 0) begin
        cmp("R2 mem_req_addr", mem_req_addr, (m_base + m_idx) & 32'hffff_ffff);
        cmp("R3 mem_req_write", mem_req_write, m_dir);
        cmp("R3 buf_addr", buf_addr, m_idx);
        if (m_dir != 0) cmp("R3 mem_req_wdata", mem_req_wdata, bufm[m_idx[7:0]]);
      end
      cmp("R4 buf_we", buf_we, (m_busy != 0) && (m_dir == 0) && rdy);
      if (buf_we) cmp("R4 buf_wdata", buf_wdata, mem[(m_base + m_idx) & 255]);
    end
  end

  task automatic go(int l, int b, bit d);
    @(posedge clk); #1;
    xfer_len = LW'(l); dma_base = AW'(b); to_mem = d; start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hEE; bufm[i] = 8'(i + 8'hA0); end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 busy", busy, 0); cmp("R1 irq", irq, 0); cmp("R1 done", dma_done, 0);
    cmp("R1 valid", mem_req_valid, 0); cmp("R1 stat", stat_o, 0);
    cmp("R1 intr", intr_o, 0); cmp("R1 seq", seq_o, 0);

    // R3: buffer to memory, always ready
    go(5, 'h40, 1);
    wait_idle();
    for (int i = 0; i < 5; i++) cmp("R3 memory content", mem['h40 + i], 8'(i + 8'hA0));
    cmp("R3 byte past end untouched", mem['h45], 8'hEE);
    cmp("R5 irq after write", irq, 1);

    // R8: ack clears irq, done stays
    @(posedge clk); #1 irq_ack = 1;
    @(posedge clk); #1 irq_ack = 0;
    @(negedge clk);
    cmp("R8 irq cleared", irq, 0); cmp("R8 done kept", dma_done, 1);

    // R4 + R2 back-pressure: memory to buffer, throttled ready
    for (int i = 0; i < 4; i++) mem['h80 + i] = 8'(8'h51 + 3 * i);
    rmode = 1;
    go(4, 'h80, 0);
    wait_idle();
    for (int i = 0; i < 4; i++) cmp("R4 buffer content", bufm[i], 8'(8'h51 + 3 * i));
    cmp("R4 buffer past end untouched", bufm[4], 8'hA4);
    cmp("R5 status after read", stat_o, 8'h93);

    // R6: zero length
    @(posedge clk); #1 irq_ack = 1;
    @(posedge clk); #1 irq_ack = 0;
    go(0, 'h20, 1);
    @(negedge clk);
    cmp("R6 no busy", busy, 0); cmp("R6 irq", irq, 1);
    cmp("R6 target untouched", mem['h20], 8'hEE);

    // R7: start while busy ignored
    for (int i = 0; i < 8; i++) bufm[i] = 8'(8'hC0 + i);
    go(6, 'h10, 1);
    @(posedge clk); #1;
    xfer_len = 2; dma_base = 'hC0; to_mem = 0; start = 1;
    @(posedge clk); #1 start = 0;
    wait_idle();
    for (int i = 0; i < 6; i++) cmp("R7 first transfer intact", mem['h10 + i], 8'(8'hC0 + i));
    cmp("R7 second base untouched", mem['hC0], 8'hEE);
    cmp("R7 idle after", busy, 0);

    rmode = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule